// File: doc/BRIEF.md
# Standard-Definition Raster Sync Generator

This block produces the horizontal and vertical timing of a standard-definition raster from a pixel clock. A pixel counter and a line counter walk through every line of a frame. A decoder turns the counter position into a horizontal sync pulse, a vertical sync pulse, a second-field flag and an active-video window. The counter position is also brought out so that downstream logic can align its own data with the raster.

Two standards are supported: a 525-line raster and a 625-line raster. In interlaced mode the full two-field frame is generated. In progressive mode only the first-field timing is produced, over and over. Successive fields alternate between a short and a long length, so each pair of fields spans exactly one interlaced frame. This keeps the average rate locked to 30 or 25 frames per second and prevents it from slowly running ahead of a clock-locked decoder.

The standard select and the progressive enable are taken in only at a frame boundary. In progressive mode, every field end counts as a frame boundary. A mid-frame change therefore never tears the raster.

Top module: `raster_timing_gen`

## Requirements
- R1: `pixel_o` counts 0 up to L-1 and then returns to 0, where L is LINE_NTSC (default 858) for the 525-line standard and LINE_PAL (default 864) for the 625-line standard.
- R2: `line_o` starts at 1 and advances by one each time `pixel_o` wraps. It wraps back to 1 after N lines. N is 525 or 625 in interlaced mode.
- R3: `hsync_n_o` is low exactly while `pixel_o` < HS_W, and high on the rest of the line.
- R4: In interlaced mode, `field_o` is 1 on lines 263 and up for the 525-line standard, and on lines 313 and up for the 625-line standard; otherwise it is 0. In progressive mode, `field_o` is always 0.
- R5: For the 525-line standard, `vsync_n_o` in the first field is low from line 4 pixel 0 up to, but not including, line 7 pixel 0. In the second field it is low from line 266 pixel L/2 up to, but not including, line 269 pixel L/2. Each pulse is 3L clocks.
- R6: For the 625-line standard, `vsync_n_o` in the first field is low from line 1 pixel 0 up to line 3 pixel L/2. In the second field it is low from line 312 pixel L/2 and rises exactly at line 315 pixel 0. Each pulse is 2.5L clocks.
- R7: In progressive mode, field lengths alternate between short and long: 262/263 lines for the 525-line standard and 312/313 lines for the 625-line standard. The first progressive field after a reset, or after an interlaced frame, is short. Every field uses first-field sync and window timing.
- R8: `active_o` is high on whole lines. For the 525-line standard these are lines 22–261 and 285–524. For the 625-line standard they are lines 23–310 and 336–622. The second range applies only in interlaced mode.
- R9: `pal_sel_i` (1 = 625-line) and `prog_en_i` (1 = progressive) are sampled only on the clock where the counters wrap to line 1 pixel 0. A change in the middle of a frame has no effect on the ongoing frame.
- R10: While `rst_n` is low, the counters sit at line 1 pixel 0, the short/long state is cleared, and the current select inputs are adopted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pal_sel_i | input | 1 | 1 selects the 625-line standard, 0 the 525-line standard |
| prog_en_i | input | 1 | 1 selects progressive (repeated first field) mode |
| hsync_n_o | output | 1 | Active-low horizontal sync |
| vsync_n_o | output | 1 | Active-low vertical sync |
| field_o | output | 1 | 1 during the second field |
| active_o | output | 1 | High on active-video lines |
| line_o | output | 10 | Current line, counting from 1 |
| pixel_o | output | 11 | Current pixel within the line, counting from 0 |

## Verification
A reference model steps alongside the design through four patterns. The first pattern is an interlaced frame of each standard, which separates the two line lengths and the first-field and second-field sync placements. The second is a progressive run of each standard, which shows whether the field lengths really alternate and sum to one frame, instead of repeating a fixed short field. The third is a mid-frame select flip, which tells a boundary-latched configuration from one that is applied at once. Seeded random select changes at arbitrary times then mix all of these transitions, including progressive-to-interlaced switches, against the model.

// File: rtl/raster_pkg.sv
package raster_pkg;

    localparam int LN_W       = 10;
    localparam int PX_W       = 11;
    localparam int LINES_525  = 525;
    localparam int LINES_625  = 625;

    typedef struct packed {
        logic [PX_W-1:0] px;
        logic [LN_W-1:0] ln;
        logic            pal;
        logic            prog;
        logic            lng;
    } raster_st_t;

    // Number of lines in the current field or frame
    function automatic logic [LN_W-1:0] field_lines(logic pal, logic prog, logic lng);
        int n;
        if (prog) n = pal ? (lng ? 313 : 312) : (lng ? 263 : 262);
        else      n = pal ? LINES_625 : LINES_525;
        return LN_W'(n);
    endfunction

    // Raster position (ln,px) is at or after (l,p)
    function automatic logic pos_ge(logic [LN_W-1:0] ln, logic [PX_W-1:0] px, int l, int p);
        return (int'(ln) > l) || ((int'(ln) == l) && (int'(px) >= p));
    endfunction

endpackage

// File: rtl/raster_counter.sv
module raster_counter
    import raster_pkg::*;
#(
    parameter int LINE_NTSC = 858,
    parameter int LINE_PAL  = 864
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pal_sel_i,
    input  logic       prog_en_i,
    output raster_st_t st_o
);

    localparam logic [PX_W-1:0] LAST_N = PX_W'(LINE_NTSC - 1);
    localparam logic [PX_W-1:0] LAST_P = PX_W'(LINE_PAL - 1);

    raster_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.px == (st_q.pal ? LAST_P : LAST_N)) begin
            st_d.px = '0;
            if (st_q.ln == field_lines(st_q.pal, st_q.prog, st_q.lng)) begin
                st_d.ln   = LN_W'(1);
                st_d.pal  = pal_sel_i;
                st_d.prog = prog_en_i;
                st_d.lng  = (prog_en_i && st_q.prog) ? ~st_q.lng : 1'b0;
            end else begin
                st_d.ln = st_q.ln + LN_W'(1);
            end
        end else begin
            st_d.px = st_q.px + PX_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.px   <= '0;
            st_q.ln   <= LN_W'(1);
            st_q.pal  <= pal_sel_i;
            st_q.prog <= prog_en_i;
            st_q.lng  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign st_o = st_q;

endmodule

// File: rtl/raster_decode.sv
module raster_decode
    import raster_pkg::*;
#(
    parameter int LINE_NTSC = 858,
    parameter int LINE_PAL  = 864,
    parameter int HS_W      = 64
) (
    input  raster_st_t st_i,
    output logic       hsync_n_o,
    output logic       vsync_n_o,
    output logic       field_o,
    output logic       active_o
);

    localparam int HALF_N = LINE_NTSC / 2;
    localparam int HALF_P = LINE_PAL / 2;

    logic vs_a, vs_b, act_a, act_b, second;
    int   ln;

    always_comb begin
        ln = int'(st_i.ln);
        if (!st_i.pal) begin
            vs_a   = pos_ge(st_i.ln, st_i.px, 4, 0)        && !pos_ge(st_i.ln, st_i.px, 7, 0);
            vs_b   = pos_ge(st_i.ln, st_i.px, 266, HALF_N) && !pos_ge(st_i.ln, st_i.px, 269, HALF_N);
            act_a  = (ln >= 22)  && (ln <= 261);
            act_b  = (ln >= 285) && (ln <= 524);
            second = (ln >= 263);
        end else begin
            vs_a   = pos_ge(st_i.ln, st_i.px, 1, 0)        && !pos_ge(st_i.ln, st_i.px, 3, HALF_P);
            vs_b   = pos_ge(st_i.ln, st_i.px, 312, HALF_P) && !pos_ge(st_i.ln, st_i.px, 315, 0);
            act_a  = (ln >= 23)  && (ln <= 310);
            act_b  = (ln >= 336) && (ln <= 622);
            second = (ln >= 313);
        end
        if (st_i.prog) begin
            vs_b   = 1'b0;
            act_b  = 1'b0;
            second = 1'b0;
        end
        hsync_n_o = !(int'(st_i.px) < HS_W);
        vsync_n_o = !(vs_a || vs_b);
        field_o   = second;
        active_o  = act_a || act_b;
    end

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
    import raster_pkg::*;
#(
    parameter int LINE_NTSC = 858,
    parameter int LINE_PAL  = 864,
    parameter int HS_W      = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pal_sel_i,
    input  logic            prog_en_i,
    output logic            hsync_n_o,
    output logic            vsync_n_o,
    output logic            field_o,
    output logic            active_o,
    output logic [LN_W-1:0] line_o,
    output logic [PX_W-1:0] pixel_o
);

    raster_st_t st;

    raster_counter #(.LINE_NTSC(LINE_NTSC), .LINE_PAL(LINE_PAL)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .pal_sel_i (pal_sel_i),
        .prog_en_i (prog_en_i),
        .st_o      (st)
    );

    raster_decode #(.LINE_NTSC(LINE_NTSC), .LINE_PAL(LINE_PAL), .HS_W(HS_W)) u_dec (
        .st_i      (st),
        .hsync_n_o (hsync_n_o),
        .vsync_n_o (vsync_n_o),
        .field_o   (field_o),
        .active_o  (active_o)
    );

    assign line_o  = st.ln;
    assign pixel_o = st.px;

endmodule

// File: rtl/raster_timing_chk.sv
module raster_timing_chk
    import raster_pkg::*;
#(
    parameter int LINE_NTSC = 858,
    parameter int LINE_PAL  = 864
) (
    input logic            clk,
    input logic            rst_n,
    input logic            hsync_n_o,
    input logic            vsync_n_o,
    input logic            field_o,
    input logic [LN_W-1:0] line_o,
    input logic [PX_W-1:0] pixel_o
);

    AST_PIXEL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pixel_o == $past(pixel_o) + PX_W'(1)) || (pixel_o == '0))); // R1

    AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pixel_o != '0) |-> $stable(line_o)); // R2

    AST_LINE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (line_o >= LN_W'(1)) && (line_o <= LN_W'(LINES_625))); // R2

    AST_HSYNC_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        (pixel_o == '0) |-> !hsync_n_o); // R3

    AST_FIELD_LATE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        field_o |-> (line_o >= LN_W'(263))); // R4

    AST_VSYNC_EDGE_POS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vsync_n_o) |-> ((pixel_o == '0) || (int'(pixel_o) == LINE_NTSC / 2)
                              || (int'(pixel_o) == LINE_PAL / 2))); // R5

endmodule

bind raster_timing_gen raster_timing_chk #(.LINE_NTSC(LINE_NTSC), .LINE_PAL(LINE_PAL)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hsync_n_o (hsync_n_o),
    .vsync_n_o (vsync_n_o),
    .field_o   (field_o),
    .line_o    (line_o),
    .pixel_o   (pixel_o)
);

// File: tb/sim_raster_timing_gen.sv
`timescale 1ns/1ps
module sim_raster_timing_gen;

    localparam int LN  = 16;
    localparam int LP  = 18;
    localparam int HSW = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pal_sel = 1'b0;
    logic        prog_en = 1'b0;
    logic        hsync_n, vsync_n, field, active;
    logic [9:0]  line;
    logic [10:0] pixel;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #4 clk = ~clk;

    raster_timing_gen #(.LINE_NTSC(LN), .LINE_PAL(LP), .HS_W(HSW)) u0 (
        .clk(clk), .rst_n(rst_n), .pal_sel_i(pal_sel), .prog_en_i(prog_en),
        .hsync_n_o(hsync_n), .vsync_n_o(vsync_n), .field_o(field), .active_o(active),
        .line_o(line), .pixel_o(pixel)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (line %0d pixel %0d)", req, act, exp, line, pixel);
        end
    endtask

    // ---------------- expected-value functions ----------------
    function automatic bit at_or_after(int l, int p, int L, int P);
        return (l > L) || (l == L && p >= P);
    endfunction

    function automatic int len_of(bit pal);
        return pal ? LP : LN;
    endfunction

    function automatic int lines_of(bit pal, bit prog, bit lng);
        if (prog) return pal ? (lng ? 313 : 312) : (lng ? 263 : 262);
        return pal ? 625 : 525;
    endfunction

    function automatic bit e_vlow(bit pal, bit prog, int l, int p);
        int h = len_of(pal) / 2;
        bit a, b;
        if (!pal) begin
            a = at_or_after(l, p, 4, 0) && !at_or_after(l, p, 7, 0);
            b = at_or_after(l, p, 266, h) && !at_or_after(l, p, 269, h);
        end else begin
            a = at_or_after(l, p, 1, 0) && !at_or_after(l, p, 3, h);
            b = at_or_after(l, p, 312, h) && !at_or_after(l, p, 315, 0);
        end
        return a || (b && !prog);
    endfunction

    function automatic bit e_field(bit pal, bit prog, int l);
        return !prog && (l >= (pal ? 313 : 263));
    endfunction

    function automatic bit e_active(bit pal, bit prog, int l);
        bit a = pal ? (l >= 23 && l <= 310) : (l >= 22 && l <= 261);
        bit b = pal ? (l >= 336 && l <= 622) : (l >= 285 && l <= 524);
        return a || (b && !prog);
    endfunction

    // ---------------- reference model (R9, R10 rules) ----------------
    int m_px = 0, m_ln = 1;
    bit m_pal = 0, m_prog = 0, m_lng = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_px <= 0; m_ln <= 1; m_pal <= pal_sel; m_prog <= prog_en; m_lng <= 0;
        end else if (m_px == len_of(m_pal) - 1) begin
            m_px <= 0;
            if (m_ln == lines_of(m_pal, m_prog, m_lng)) begin
                m_ln <= 1; m_pal <= pal_sel; m_prog <= prog_en;
                m_lng <= (prog_en && m_prog) ? !m_lng : 1'b0;
            end else begin
                m_ln <= m_ln + 1;
            end
        end else begin
            m_px <= m_px + 1;
        end
    end

    // ---------------- monitors ----------------
    int vlow_cnt = 0;
    bit vs_prev = 1'b1;
    int fcnt = 0, flen_prev = 0, flen_prev2 = 0;
    int field_hi = 0;
    int act_first = 0, act_last = 0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            chk(int'(pixel) == m_px, "R1 pixel", int'(pixel), m_px);
            chk(int'(line) == m_ln, "R2 line", int'(line), m_ln);
            chk(hsync_n == !(m_px < HSW), "R3 hsync", hsync_n, !(m_px < HSW));
            chk(field == e_field(m_pal, m_prog, m_ln), "R4 field", field, e_field(m_pal, m_prog, m_ln));
            chk(vsync_n == !e_vlow(m_pal, m_prog, m_ln, m_px), m_pal ? "R6 vsync" : "R5 vsync",
                vsync_n, !e_vlow(m_pal, m_prog, m_ln, m_px));
            chk(active == e_active(m_pal, m_prog, m_ln), "R8 active", active, e_active(m_pal, m_prog, m_ln));
            // pulse width and PAL second-field rise position
            if (!vsync_n) vlow_cnt++;
            else if (!vs_prev) begin
                chk(vlow_cnt == (m_pal ? (LP * 5) / 2 : LN * 3), m_pal ? "R6 width" : "R5 width",
                    vlow_cnt, m_pal ? (LP * 5) / 2 : LN * 3);
                if (m_pal && line > 300)
                    chk(line == 315 && pixel == 0, "R6 rise", int'(line), 315);
                vlow_cnt = 0;
            end
            vs_prev = vsync_n;
            if (line == 1 && pixel == 0) begin
                flen_prev2 = flen_prev; flen_prev = fcnt; fcnt = 1;
            end else fcnt++;
            if (field) field_hi++;
            if (active && line > 312) begin
                if (act_first == 0) act_first = int'(line);
                act_last = int'(line);
            end
        end else begin
            vlow_cnt = 0; vs_prev = 1'b1; fcnt = 0;
        end
    end

    task automatic wait_start();
        do @(negedge clk); while (!(line == 1 && pixel == 0));
        #1;
    endtask

    task automatic do_reset(input bit pal, input bit prog);
        @(negedge clk);
        rst_n = 1'b0; pal_sel = pal; prog_en = prog;
        repeat (3) @(negedge clk);
        chk(line == 1 && pixel == 0, "R10 reset position", int'(line) * 1000 + int'(pixel), 1000);
        chk(hsync_n == 1'b0, "R10 reset hsync", hsync_n, 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic prog_run(input bit pal);
        int unit = pal ? LP : LN;
        int tot  = pal ? 625 : 525;
        do_reset(pal, 1'b1);
        field_hi = 0;
        repeat (4) wait_start();
        chk(flen_prev + flen_prev2 == tot * unit, "R7 pair sum", flen_prev + flen_prev2, tot * unit);
        chk(flen_prev - flen_prev2 == unit || flen_prev2 - flen_prev == unit, "R7 alternate",
            flen_prev - flen_prev2, unit);
        chk(field_hi == 0, "R4 progressive field", field_hi, 0);
    endtask

    initial begin
        void'($urandom(32'd7));
        // NTSC interlaced, mid-frame flip to PAL
        do_reset(1'b0, 1'b0);
        do @(negedge clk); while (line != 100);
        pal_sel = 1'b1;
        do @(negedge clk); while (!(line == 200 && pixel == LN - 1));
        @(negedge clk);
        chk(pixel == 0, "R9 line length kept", int'(pixel), 0);
        wait_start();
        repeat (17) @(negedge clk);
        chk(pixel == 17 && line == 1, "R9 new standard at boundary", int'(pixel), 17);
        // PAL interlaced second-field active window
        act_first = 0; act_last = 0;
        wait_start();
        chk(act_first == 336, "R8 window start", act_first, 336);
        chk(act_last == 622, "R8 window end", act_last, 622);
        // progressive runs
        prog_run(1'b0);
        prog_run(1'b1);
        // random select changes
        for (int i = 0; i < 40; i++) begin
            repeat ($urandom_range(300, 2500)) @(negedge clk);
            pal_sel = 1'($urandom % 2);
            prog_en = 1'($urandom % 2);
        end
        repeat (100) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        wait (cyc >= 195000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=<195000", cyc);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule